// File: doc/BRIEF.md
# SD Card SPI Command Engine

This block runs one complete command exchange with an SD card in SPI mode. A one-cycle start pulse latches a 6-bit command index, a 32-bit argument and a response kind. The block then sends the six-byte command frame through a byte-wide request/acknowledge port to an external SPI shifter. The frame's CRC7 check byte is computed one byte at a time while the frame is being sent.

After the frame, the block keeps sending 0xFF fill bytes and watches the returned bytes for the first valid response byte. The number of polls is bounded. Depending on the response kind, it then collects trailing status bytes. It always finishes with a fixed run of 0xFF trailer bytes. A done pulse marks the moment the response, the extended word and the timeout flag are final. Chip-select control, clock-rate selection and data-block movement stay with the caller.

Top module: `sd_cmd_engine`

## Requirements
- R1: A start pulse while idle latches command, argument and response kind, and busy_o is high one clock later. A start pulse while busy is ignored: the frame in flight and the byte count are unchanged, and only one done pulse follows.
- R2: The frame begins with 0x40 OR the command index, followed by the four argument bytes, most significant first.
- R3: The sixth frame byte is a CRC7 with bit 0 forced to 1. The register starts at 0 and is updated once for each of the first five frame bytes. Each update XORs the byte into the register, then repeats 8 times: XOR 0x89 if bit 7 is set, then shift left by one.
- R4: After the frame, the block sends 0xFF while polling. The first received byte with bit 7 clear becomes r1_o, and bytes with bit 7 set (0xFF or any other value) are skipped.
- R5: If no byte with bit 7 clear arrives within POLL_LIMIT (default 1000) poll bytes, timeout_o is set, r1_o reads 0xFF, resp_o is 0 and no trailing bytes are read. A valid byte on exactly the last allowed poll is accepted as the response.
- R6: Kind 2'b01 (R2) reads exactly one more byte after the response, and resp_o = {16'h0, r1, byte}.
- R7: Kind 2'b10 (R3/R7) reads four more bytes into resp_o, most significant first, only when r1 is 0x01. For any other r1, resp_o stays 0 and no extra bytes are read.
- R8: After the response phase, including a timeout, the block sends DUMMY_BYTES (default 8) 0xFF bytes. Then done_o pulses for one cycle, and busy_o is low in that same cycle.
- R9: Kind 2'b00 and kind 2'b11 both read only the single response byte, and resp_o is 0.
- R10: After reset: busy_o, done_o, spi_req_o and timeout_o are 0, r1_o is 0xFF and resp_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a command |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| resp_kind_i | input | 2 | 00 R1, 01 R2, 10 R3/R7, 11 as R1 |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| r1_o | output | 8 | First response byte, 0xFF on timeout |
| resp_o | output | 32 | Extended response word |
| timeout_o | output | 1 | No response within the poll limit |
| spi_req_o | output | 1 | Byte exchange request |
| spi_tx_o | output | 8 | Byte to send, held while requested |
| spi_ack_i | input | 1 | Exchange complete this cycle |
| spi_rx_i | input | 8 | Byte received, valid with spi_ack_i |

## Verification
The riskiest clash is a valid response byte arriving on the same exchange in which the poll counter reaches its limit. Here response capture and timeout detection compete for one edge.

The bench places a 0x00 reply on exactly poll byte 1000 and expects a clean response with no timeout and 1014 exchanges. A second case places the same reply one byte later and expects the timeout path. In that case the late byte must be swallowed as the first trailer byte without changing r1_o.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  typedef enum logic [1:0] {
    RESP_R1  = 2'b00,
    RESP_R2  = 2'b01,
    RESP_R37 = 2'b10,
    RESP_RSV = 2'b11
  } resp_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_POLL,
    ST_TAIL,
    ST_DUMMY
  } eng_state_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam int unsigned FRAME_BYTES = 6;
endpackage

// File: rtl/sd_crc7_step.sv
module sd_crc7_step #(
  parameter logic [7:0] POLY = 8'h89
) (
  input  logic [7:0] crc_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  logic [7:0] stage [0:8];

  assign stage[0] = crc_i ^ data_i;

  for (genvar i = 0; i < 8; i++) begin : g_bit
    logic [7:0] mixed;
    assign mixed        = stage[i][7] ? (stage[i] ^ POLY) : stage[i];
    assign stage[i+1]   = {mixed[6:0], 1'b0};
  end

  assign crc_o = stage[8];
endmodule

// File: rtl/sd_byte_counter.sv
module sd_byte_counter #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  // count never passes the last slot of the window
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int unsigned POLL_LIMIT  = 1000,
  parameter int unsigned DUMMY_BYTES = 8,
  parameter logic [7:0]  CRC_POLY    = 8'h89
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [5:0]  cmd_idx_i,
  input  logic [31:0] cmd_arg_i,
  input  logic [1:0]  resp_kind_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  r1_o,
  output logic [31:0] resp_o,
  output logic        timeout_o,
  output logic        spi_req_o,
  output logic [7:0]  spi_tx_o,
  input  logic        spi_ack_i,
  input  logic [7:0]  spi_rx_i
);
  localparam logic [2:0] LAST_FRAME = 3'(FRAME_BYTES - 1);

  eng_state_e  state_q;
  resp_kind_e  kind_q;
  logic [39:0] frame_q;
  logic [7:0]  crc_q, crc_nxt;
  logic [2:0]  step_q;
  logic [7:0]  r1_q;
  logic [31:0] resp_q;
  logic        timeout_q, done_q;
  logic        xfer, poll_last, dummy_last;
  logic        in_poll, in_dummy;
  logic [2:0]  tail_last;
  logic        want_tail;

  assign busy_o    = (state_q != ST_IDLE);
  assign spi_req_o = busy_o;
  assign xfer      = spi_req_o & spi_ack_i;
  assign in_poll   = (state_q == ST_POLL);
  assign in_dummy  = (state_q == ST_DUMMY);

  always_comb begin
    spi_tx_o = FILL_BYTE;
    if (state_q == ST_FRAME)
      spi_tx_o = (step_q == LAST_FRAME) ? {crc_q[7:1], 1'b1} : frame_q[39:32];
  end

  sd_crc7_step #(.POLY(CRC_POLY)) u_crc (
    .crc_i (crc_q),
    .data_i(frame_q[39:32]),
    .crc_o (crc_nxt)
  );

  sd_byte_counter #(.LIMIT(POLL_LIMIT)) u_poll_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!in_poll),
    .inc_i (in_poll & xfer & !poll_last),
    .last_o(poll_last)
  );

  sd_byte_counter #(.LIMIT(DUMMY_BYTES)) u_dummy_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!in_dummy),
    .inc_i (in_dummy & xfer & !dummy_last),
    .last_o(dummy_last)
  );

  assign tail_last = (kind_q == RESP_R2) ? 3'd0 : 3'd3;
  assign want_tail = (kind_q == RESP_R2) ||
                     ((kind_q == RESP_R37) && (spi_rx_i == 8'h01));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= RESP_R1;
      frame_q   <= '0;
      crc_q     <= '0;
      step_q    <= '0;
      r1_q      <= FILL_BYTE;
      resp_q    <= '0;
      timeout_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_FRAME;
          kind_q    <= resp_kind_e'(resp_kind_i);
          frame_q   <= {2'b01, cmd_idx_i, cmd_arg_i};
          crc_q     <= '0;
          step_q    <= '0;
          r1_q      <= FILL_BYTE;
          resp_q    <= '0;
          timeout_q <= 1'b0;
        end
        ST_FRAME: if (xfer) begin
          if (step_q == LAST_FRAME) begin
            state_q <= ST_POLL;
            step_q  <= '0;
          end else begin
            frame_q <= {frame_q[31:0], 8'h00};
            crc_q   <= crc_nxt;
            step_q  <= step_q + 3'd1;
          end
        end
        ST_POLL: if (xfer) begin
          // a valid byte on the final poll wins over timeout
          if (!spi_rx_i[7]) begin
            r1_q    <= spi_rx_i;
            state_q <= want_tail ? ST_TAIL : ST_DUMMY;
          end else if (poll_last) begin
            timeout_q <= 1'b1;
            state_q   <= ST_DUMMY;
          end
        end
        ST_TAIL: if (xfer) begin
          resp_q <= (kind_q == RESP_R2) ? {16'h0, r1_q, spi_rx_i}
                                        : {resp_q[23:0], spi_rx_i};
          if (step_q == tail_last) state_q <= ST_DUMMY;
          else                     step_q  <= step_q + 3'd1;
        end
        ST_DUMMY: if (xfer && dummy_last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o    = done_q;
  assign r1_o      = r1_q;
  assign resp_o    = resp_q;
  assign timeout_o = timeout_q;

  p_tx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_req_o && !spi_ack_i) |=> $stable(spi_tx_o));
  p_busy_from_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  p_r1_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !timeout_o) |-> !r1_o[7]);
  p_timeout_ff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (r1_o == 8'hFF && resp_o == 32'h0));
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_DEPTH  = 1200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd = '0;
  logic [31:0] arg = '0;
  logic [1:0]  kind = '0;
  logic        busy, done, timeout, req, ack_q;
  logic [7:0]  r1, tx, rx;
  logic [31:0] resp;
  logic        clr_log = 1'b0;
  int          xfer_cnt, done_cnt;
  int          n_chk = 0, n_bad = 0;
  logic [7:0]  rx_script [0:LOG_DEPTH-1];
  logic [7:0]  tx_log    [0:LOG_DEPTH-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_engine u_sd_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_idx_i(cmd),
    .cmd_arg_i(arg), .resp_kind_i(kind), .busy_o(busy), .done_o(done),
    .r1_o(r1), .resp_o(resp), .timeout_o(timeout), .spi_req_o(req),
    .spi_tx_o(tx), .spi_ack_i(ack_q), .spi_rx_i(rx)
  );

  // card/shifter model: ack every other cycle while requested
  assign rx = (xfer_cnt < LOG_DEPTH) ? rx_script[xfer_cnt] : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0; xfer_cnt <= 0; done_cnt <= 0;
    end else begin
      ack_q <= req && !ack_q;
      if (clr_log) begin
        xfer_cnt <= 0; done_cnt <= 0;
      end else begin
        if (req && ack_q) begin
          if (xfer_cnt < LOG_DEPTH) tx_log[xfer_cnt] <= tx;
          xfer_cnt <= xfer_cnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_exp(input logic [39:0] f);
    logic [7:0] t = 8'h00;
    for (int j = 0; j < 5; j++) begin
      t ^= f[39-8*j -: 8];
      for (int i = 0; i < 8; i++) begin
        if (t[7]) t ^= 8'h89;
        t = t << 1;
      end
    end
    return t | 8'h01;
  endfunction

  task automatic fill_ff();
    for (int i = 0; i < LOG_DEPTH; i++) rx_script[i] = 8'hFF;
  endtask

  task automatic launch(input logic [5:0] c, input logic [31:0] a, input logic [1:0] k);
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
    cmd = c; arg = a; kind = k; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R1 busy after start", 32'(busy), 32'd1);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk("R8 done reached", 32'(done), 32'd1);
    chk("R8 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R8 done is one pulse", 32'(done), 32'd0);
  endtask

  task automatic chk_frame(input logic [5:0] c, input logic [31:0] a);
    logic [39:0] f = {2'b01, c, a};
    for (int j = 0; j < 5; j++) chk("R2 frame byte", 32'(tx_log[j]), 32'(f[39-8*j -: 8]));
    chk("R3 crc byte", 32'(tx_log[5]), 32'(crc_exp(f)));
  endtask

  task automatic chk_fill(input int from, input int to, input string tag);
    logic ok = 1'b1;
    for (int i = from; i < to; i++) if (tx_log[i] !== 8'hFF) ok = 1'b0;
    chk(tag, 32'(ok), 32'd1);
  endtask

  task automatic t_reset();
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 req", 32'(req), 0);
    chk("R10 timeout", 32'(timeout), 0);
    chk("R10 r1", 32'(r1), 32'hFF);
    chk("R10 resp", resp, 0);
  endtask

  task automatic t_cmd0_skip();
    fill_ff();
    rx_script[7] = 8'hC1;
    rx_script[8] = 8'h01;
    launch(6'd0, 32'h0, 2'b00);
    wait_done();
    chk_frame(6'd0, 32'h0);
    chk("R3 known crc cmd0", 32'(tx_log[5]), 32'h95);
    chk("R4 r1 after skipped bytes", 32'(r1), 32'h01);
    chk("R4 poll fill", 32'(tx_log[6] & tx_log[7] & tx_log[8]), 32'hFF);
    chk("R9 r1 kind resp", resp, 0);
    chk("R8 exchange count", 32'(xfer_cnt), 32'd17);
    chk_fill(9, 17, "R8 trailer is 0xFF");
    chk("R5 no timeout", 32'(timeout), 0);
  endtask

  task automatic t_r7_ok();
    fill_ff();
    rx_script[6] = 8'h01;
    rx_script[7] = 8'h00; rx_script[8] = 8'h00;
    rx_script[9] = 8'h01; rx_script[10] = 8'hAA;
    launch(6'd8, 32'h1AA, 2'b10);
    wait_done();
    chk_frame(6'd8, 32'h1AA);
    chk("R3 known crc cmd8", 32'(tx_log[5]), 32'h87);
    chk("R7 word", resp, 32'h000001AA);
    chk("R7 exchange count", 32'(xfer_cnt), 32'd19);
    chk_fill(6, 19, "R4 R8 fill bytes");
  endtask

  task automatic t_r7_skip();
    fill_ff();
    rx_script[6] = 8'h05;
    rx_script[7] = 8'h12;
    launch(6'd58, 32'hDEADBEEF, 2'b10);
    wait_done();
    chk_frame(6'd58, 32'hDEADBEEF);
    chk("R7 r1", 32'(r1), 32'h05);
    chk("R7 resp skipped", resp, 0);
    chk("R7 no extra bytes", 32'(xfer_cnt), 32'd15);
  endtask

  task automatic t_r2();
    fill_ff();
    rx_script[6] = 8'hFF; rx_script[7] = 8'h04; rx_script[8] = 8'h42;
    launch(6'd13, 32'h0, 2'b01);
    wait_done();
    chk("R6 status", resp, 32'h00000442);
    chk("R6 one extra byte", 32'(xfer_cnt), 32'd17);
  endtask

  task automatic t_rsv_kind();
    fill_ff();
    rx_script[6] = 8'h01; rx_script[7] = 8'h33;
    launch(6'd55, 32'h0, 2'b11);
    wait_done();
    chk("R9 kind 11 r1", 32'(r1), 32'h01);
    chk("R9 kind 11 resp", resp, 0);
    chk("R9 kind 11 count", 32'(xfer_cnt), 32'd15);
  endtask

  task automatic t_last_poll();
    fill_ff();
    rx_script[6 + 999] = 8'h00;
    launch(6'd41, 32'h4000_0000, 2'b00);
    wait_done();
    chk("R5 last poll accepted", 32'(timeout), 0);
    chk("R5 last poll r1", 32'(r1), 32'h00);
    chk("R5 last poll count", 32'(xfer_cnt), 32'd1014);
  endtask

  task automatic t_timeout();
    fill_ff();
    rx_script[6 + 1000] = 8'h00;
    launch(6'd13, 32'h0, 2'b01);
    wait_done();
    chk("R5 timeout flag", 32'(timeout), 1);
    chk("R5 timeout r1", 32'(r1), 32'hFF);
    chk("R5 timeout resp", resp, 0);
    chk("R5 timeout no tail", 32'(xfer_cnt), 32'd1014);
    chk_fill(1006, 1014, "R8 trailer after timeout");
  endtask

  task automatic t_start_busy();
    fill_ff();
    rx_script[6] = 8'h00;
    launch(6'd17, 32'h0000_0200, 2'b00);
    repeat (3) @(negedge clk);
    cmd = 6'd24; arg = 32'hFFFF_FFFF; kind = 2'b10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);
    chk_frame(6'd17, 32'h0000_0200);
    chk("R1 count unchanged", 32'(xfer_cnt), 32'd15);
    chk("R1 single done", 32'(done_cnt), 32'd1);
    chk("R1 still idle", 32'(busy), 0);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    fill_ff();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_cmd0_skip();
    t_r7_ok();
    t_r7_skip();
    t_r2();
    t_rsv_kind();
    t_last_poll();
    t_timeout();
    t_start_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule